// File: doc/BRIEF.md
# Three-Tap Transmit De-Emphasis Level Mapper

This block turns a serial bit stream, one symbol per accepted clock, into a signed drive-level code for an external line driver. Each code combines three weighted terms. The main cursor carries the symbol itself. The post-cursor tap subtracts a fraction of the symbol sent before it. The pre-cursor tap subtracts a fraction of the symbol sent after it. As a result, a symbol next to a transition is driven at full swing, and a symbol that repeats its neighbour is driven at a reduced swing. The pre and post reductions are programmed separately.

To see the following symbol, the block holds each symbol back by one accepted symbol. The code for symbol n is emitted when symbol n+1 is accepted. Tap weights are sampled only when a symbol is accepted. A weight pair whose sum would let the side taps cancel or invert the main cursor is refused.

Top module: `txde_mapper`

## Requirements
- R1: After reset, `lvl_o` is 0 and `lvl_vld_o` is 0. Both stored history symbols read as bit 0.
- R2: Bit 1 maps to +1 and bit 0 maps to -1. An emitted code equals MAIN_LVL·s[n] − post·s[n−1] − pre·s[n+1], where pre and post are the weights in force, before any limiting. The default MAIN_LVL is 100.
- R3: The code for the symbol accepted at acceptance k appears on `lvl_o`, with `lvl_vld_o` high for one cycle, in the clock cycle after acceptance k+1. The first accepted symbol after reset produces no code by itself.
- R4: While `sym_vld_i` is low, `lvl_o` holds its value and `lvl_vld_o` stays low.
- R5: A result above 2^(OUT_W−1)−1 is limited to 2^(OUT_W−1)−1. A result below −2^(OUT_W−1) is limited to −2^(OUT_W−1). With OUT_W=8 these limits are 127 and −128.
- R6: A weight pair offered with an accepted symbol takes effect only if pre+post ≤ MAIN_LVL−1. Otherwise the pair is ignored and the previous pair stays in force.
- R7: Weights are sampled only on an accepted symbol. The code emitted at that acceptance already uses the newly accepted pair. Weight changes between acceptances have no effect.
- R8: The first emitted code after reset treats the symbol before it as the reset level, bit 0 (−1).
- R9: An emitted code is never zero, and its sign always matches the main-cursor symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_vld_i | input | 1 | A symbol is presented this cycle |
| sym_bit_i | input | 1 | Symbol bit |
| pre_wt_i | input | WT_W | Pre-cursor reduction weight, unsigned |
| post_wt_i | input | WT_W | Post-cursor reduction weight, unsigned |
| lvl_o | output | OUT_W | Signed drive-level code |
| lvl_vld_o | output | 1 | `lvl_o` carries a new code this cycle |

## Verification
The assertions assume that `sym_bit_i` and the weight inputs are settled whenever `sym_vld_i` is high. They also assume that reset is held for at least one clock edge before the first symbol. The bench changes all inputs only on the falling edge, so every value is stable at the sampling edge. Inputs stay stable for a whole cycle at a time. Weight sums above the limit are offered on purpose, and the sign property still holds in that case because the stored pair is never replaced by one that breaks it. Idle gaps of several cycles, and weight changes made during those gaps, check that nothing moves outside an acceptance.

// File: rtl/txde_pkg.sv
package txde_pkg;

    // Drive polarity of one symbol as seen by the level combiner.
    typedef enum logic {
        SYM_NEG = 1'b0,
        SYM_POS = 1'b1
    } sym_e;

    // Convert a raw bit to the symbol polarity.
    function automatic sym_e to_sym(input logic b);
        return b ? SYM_POS : SYM_NEG;
    endfunction

endpackage

// File: rtl/txde_hist.sv
module txde_hist
    import txde_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_i,
    input  logic bit_i,
    output sym_e prv_o,
    output sym_e cur_o,
    output logic primed_o
);

    typedef struct packed {
        sym_e prv;
        sym_e cur;
        logic primed;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc_i) begin
            st_d.prv    = st_q.cur;
            st_d.cur    = to_sym(bit_i);
            st_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{prv: SYM_NEG, cur: SYM_NEG, primed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign prv_o    = st_q.prv;
    assign cur_o    = st_q.cur;
    assign primed_o = st_q.primed;

    // History only advances on an accepted symbol.
    assert_hist_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_i |=> $stable(st_q));

endmodule

// File: rtl/txde_wt_gate.sv
module txde_wt_gate #(
    parameter int WT_W     = 7,
    parameter int MAIN_LVL = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_i,
    input  logic [WT_W-1:0] pre_i,
    input  logic [WT_W-1:0] post_i,
    output logic [WT_W-1:0] pre_nx_o,
    output logic [WT_W-1:0] post_nx_o
);

    localparam logic [WT_W:0] MAX_SUM = (WT_W+1)'(MAIN_LVL - 1);

    typedef struct packed {
        logic [WT_W-1:0] pre;
        logic [WT_W-1:0] post;
    } wt_t;

    wt_t st_d, st_q;
    logic [WT_W:0] offer_sum;
    logic          offer_ok;

    always_comb begin
        offer_sum = {1'b0, pre_i} + {1'b0, post_i};
        offer_ok  = (offer_sum <= MAX_SUM);
        st_d      = st_q;
        if (acc_i && offer_ok) begin
            st_d.pre  = pre_i;
            st_d.post = post_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pre_nx_o  = st_d.pre;
    assign post_nx_o = st_d.post;

    // The stored pair can never let the side taps reach the main cursor.
    assert_wsum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.pre} + {1'b0, st_q.post}) <= MAX_SUM);

    // Weights move only at a symbol boundary.
    assert_wt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_i |=> $stable(st_q));

endmodule

// File: rtl/txde_level.sv
module txde_level
    import txde_pkg::*;
#(
    parameter int OUT_W    = 8,
    parameter int WT_W     = 7,
    parameter int MAIN_LVL = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_i,
    input  logic                    primed_i,
    input  sym_e                    prv_i,
    input  sym_e                    cur_i,
    input  logic                    nxt_i,
    input  logic [WT_W-1:0]         pre_i,
    input  logic [WT_W-1:0]         post_i,
    output logic signed [OUT_W-1:0] lvl_o,
    output logic                    vld_o
);

    localparam int SUM_W = ((OUT_W > WT_W) ? OUT_W : WT_W) + 3;
    localparam logic signed [SUM_W-1:0] MAIN_S = SUM_W'(MAIN_LVL);
    localparam logic signed [SUM_W-1:0] OMAX_S = SUM_W'((1 << (OUT_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] OMIN_S = -SUM_W'(1 << (OUT_W-1));

    typedef struct packed {
        logic [OUT_W-1:0] lvl;
        logic             vld;
        sym_e             sym;
    } lvl_t;

    lvl_t st_d, st_q;
    logic signed [SUM_W-1:0] main_t, post_t, pre_t, raw;

    always_comb begin
        main_t = (cur_i == SYM_POS) ? MAIN_S : -MAIN_S;
        post_t = $signed({{(SUM_W-WT_W){1'b0}}, post_i});
        pre_t  = $signed({{(SUM_W-WT_W){1'b0}}, pre_i});
        // Subtract each neighbour's weighted polarity.
        raw = main_t
            + ((prv_i == SYM_POS) ? -post_t : post_t)
            + (nxt_i ? -pre_t : pre_t);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (acc_i && primed_i) begin
            st_d.vld = 1'b1;
            st_d.sym = cur_i;
            if (raw > OMAX_S) begin
                st_d.lvl = OMAX_S[OUT_W-1:0];
            end else if (raw < OMIN_S) begin
                st_d.lvl = OMIN_S[OUT_W-1:0];
            end else begin
                st_d.lvl = raw[OUT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lvl: '0, vld: 1'b0, sym: SYM_NEG};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = $signed(st_q.lvl);
    assign vld_o = st_q.vld;

    // Emitted sign follows the main-cursor symbol and is never zero.
    assert_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.lvl != '0) && (st_q.lvl[OUT_W-1] == (st_q.sym == SYM_NEG)));

endmodule

// File: rtl/txde_mapper.sv
module txde_mapper #(
    parameter int OUT_W    = 8,
    parameter int WT_W     = 7,
    parameter int MAIN_LVL = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_vld_i,
    input  logic                    sym_bit_i,
    input  logic [WT_W-1:0]         pre_wt_i,
    input  logic [WT_W-1:0]         post_wt_i,
    output logic signed [OUT_W-1:0] lvl_o,
    output logic                    lvl_vld_o
);

    import txde_pkg::*;

    sym_e            prv_s, cur_s;
    logic            primed;
    logic [WT_W-1:0] pre_nx, post_nx;

    txde_hist u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (sym_vld_i),
        .bit_i    (sym_bit_i),
        .prv_o    (prv_s),
        .cur_o    (cur_s),
        .primed_o (primed)
    );

    txde_wt_gate #(.WT_W(WT_W), .MAIN_LVL(MAIN_LVL)) u_wt (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (sym_vld_i),
        .pre_i     (pre_wt_i),
        .post_i    (post_wt_i),
        .pre_nx_o  (pre_nx),
        .post_nx_o (post_nx)
    );

    txde_level #(.OUT_W(OUT_W), .WT_W(WT_W), .MAIN_LVL(MAIN_LVL)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (sym_vld_i),
        .primed_i (primed),
        .prv_i    (prv_s),
        .cur_i    (cur_s),
        .nxt_i    (sym_bit_i),
        .pre_i    (pre_nx),
        .post_i   (post_nx),
        .lvl_o    (lvl_o),
        .vld_o    (lvl_vld_o)
    );

    // No new code without a fresh acceptance in the cycle before.
    assert_vld_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_vld_o |-> $past(sym_vld_i));

    // Output holds through idle cycles.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld_i |=> $stable(lvl_o) && !lvl_vld_o);

endmodule

// File: tb/sim_txde_mapper.sv
module sim_txde_mapper;

    localparam int OUT_W = 8;
    localparam int WT_W  = 7;
    localparam int MAIN  = 100;
    localparam int NVEC  = 16;

    // Entry: {bit, pre[6:0], post[6:0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b1, 7'd10, 7'd20}, {1'b1, 7'd10, 7'd20}, {1'b0, 7'd10, 7'd20},
        {1'b0, 7'd10, 7'd20}, {1'b1, 7'd0,  7'd30}, {1'b0, 7'd0,  7'd30},
        {1'b1, 7'd25, 7'd0},  {1'b1, 7'd25, 7'd0},  {1'b1, 7'd25, 7'd0},
        {1'b0, 7'd15, 7'd15}, {1'b1, 7'd15, 7'd15}, {1'b0, 7'd60, 7'd60},
        {1'b0, 7'd5,  7'd35}, {1'b1, 7'd5,  7'd35}, {1'b1, 7'd0,  7'd0},
        {1'b0, 7'd0,  7'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_vld_i = 1'b0;
    logic sym_bit_i = 1'b0;
    logic [WT_W-1:0] pre_wt_i = '0;
    logic [WT_W-1:0] post_wt_i = '0;
    logic signed [OUT_W-1:0] lvl_o;
    logic lvl_vld_o;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model state
    logic m_prv, m_cur;
    int   m_pre, m_post, m_cnt;

    always #4 clk = ~clk;

    txde_mapper #(.OUT_W(OUT_W), .WT_W(WT_W), .MAIN_LVL(MAIN)) u0 (
        .clk(clk), .rst_n(rst_n), .sym_vld_i(sym_vld_i), .sym_bit_i(sym_bit_i),
        .pre_wt_i(pre_wt_i), .post_wt_i(post_wt_i),
        .lvl_o(lvl_o), .lvl_vld_o(lvl_vld_o)
    );

    function automatic int pol(input logic b);
        return b ? 1 : -1;
    endfunction

    function automatic int expect_lvl(input logic p, input logic c, input logic n,
                                      input int pre, input int post);
        int v;
        v = MAIN * pol(c) - post * pol(p) - pre * pol(n);
        if (v > 127) v = 127;
        if (v < -128) v = -128;
        return v;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sym_vld_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_prv = 1'b0; m_cur = 1'b0; m_pre = 0; m_post = 0; m_cnt = 0;
    endtask

    // Present one symbol, then check at the following falling edge.
    task automatic send(input logic b, input int pre, input int post, input string tag);
        int e;
        @(negedge clk);
        sym_vld_i = 1'b1; sym_bit_i = b;
        pre_wt_i = WT_W'(pre); post_wt_i = WT_W'(post);
        if (pre + post <= MAIN - 1) begin
            m_pre = pre; m_post = post;
        end
        @(posedge clk);
        @(negedge clk);
        sym_vld_i = 1'b0;
        if (m_cnt >= 1) begin
            e = expect_lvl(m_prv, m_cur, b, m_pre, m_post);
            chk(int'(lvl_o), e, tag);
            chk(int'(lvl_vld_o), 1, {tag, " vld"});
        end else begin
            chk(int'(lvl_vld_o), 0, "R3 first symbol no code");
        end
        m_prv = m_cur; m_cur = b; m_cnt++;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic signed [OUT_W-1:0] held;
        do_reset();
        // R1 reset state
        chk(int'(lvl_o), 0, "R1 lvl after reset");
        chk(int'(lvl_vld_o), 0, "R1 vld after reset");

        // R8: first code uses reset-level previous symbol 0
        send(1'b1, 10, 20, "R3 first accept");
        send(1'b1, 10, 20, "R8 first code");

        // Vector walk: R2 levels and R6 refused pair at entry 11
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][14], int'(VEC[i][13:7]), int'(VEC[i][6:0]),
                 (i == 11 || i == 12) ? "R6 refused pair" : "R2 level");
        end

        // R4 idle gap and R7 weight change without acceptance
        held = lvl_o;
        @(negedge clk);
        pre_wt_i = 7'd40; post_wt_i = 7'd40; sym_bit_i = ~sym_bit_i;
        repeat (3) @(negedge clk);
        chk(int'(lvl_o), int'(held), "R4 hold in gap");
        chk(int'(lvl_vld_o), 0, "R4 vld low in gap");
        send(1'b1, 5, 5, "R7 new pair at accept");
        send(1'b0, 5, 5, "R7 steady pair");

        // R5 limiting both directions
        send(1'b1, 50, 49, "R5 setup");
        send(1'b0, 50, 49, "R5 positive limit");
        send(1'b1, 50, 49, "R5 negative limit");
        send(1'b0, 50, 49, "R5 positive limit again");

        // R3 latency across a gap: code appears only after next acceptance
        @(negedge clk);
        repeat (2) @(negedge clk);
        chk(int'(lvl_vld_o), 0, "R3 no code before next symbol");
        send(1'b0, 50, 49, "R3 code after next symbol");

        // R1 again: reset mid-stream clears history
        do_reset();
        chk(int'(lvl_o), 0, "R1 lvl after second reset");
        send(1'b0, 0, 30, "R3 first accept after reset");
        send(1'b0, 0, 30, "R8 reset level history");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule